// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block turns three external interrupt pins into per-channel interrupt requests for a processor. Channels 0 and 1 are sampled on the system clock. Each has a two-bit sense code that selects one of four conditions: a low level, any change, a falling edge or a rising edge. Channel 2 captures its edge without the clock, through a flop driven by the pin itself, and a one-bit polarity select chooses the falling or the rising edge. Each edge-type event sets a sticky flag. A flag is cleared when software writes a one to its bit, or when the processor acknowledges that channel.

Software programs the block through a small synchronous register bus. The registers hold the sense codes, the per-channel enables, the channel 2 polarity and the flags. A request reaches the processor only when the channel's enable bit and the global interrupt-enable input are both set. Changing the channel 2 polarity can itself look like an edge. Software therefore masks the channel, changes the polarity, clears the flag and then unmasks the channel.

Top module: `ext_irq_sense`

## Requirements
- R1: After reset, every register reads zero and all three requests are low.
- R2: In a synchronous channel, sense code 2'b10 sets the flag on a falling pin edge and 2'b11 sets it on a rising edge. The opposite edge leaves the flag clear.
- R3: Sense code 2'b01 sets the flag on both a rising and a falling pin edge.
- R4: Sense code 2'b00 drives the request directly from the synchronised pin being low, and no flag is ever set in this mode. When the pin returns high, the request drops and nothing remains recorded.
- R5: A request is asserted only when both the channel enable and `gie` are 1. A flag is set whatever the enable is.
- R6: Writing 1 to a flag bit at address 3 clears that flag. Writing 0 leaves it unchanged.
- R7: `ack` with `ack_id` = n clears the flag of channel n and no other flag. When a new event and a clear fall in the same cycle, the flag ends up set.
- R8: For channel 2, a polarity bit of 0 selects the falling edge and 1 selects the rising edge. The other edge is ignored.
- R9: A polarity change that looks like the selected edge sets the channel 2 flag. With the sequence mask, change polarity, clear the flag, unmask, no request appears.
- R10: Register map. Address 0 holds the channel 0 sense code in bits [1:0] and the channel 1 sense code in bits [3:2]. Address 1 holds the enables: channel 1 in bit 7, channel 0 in bit 6 and channel 2 in bit 5. Address 2 holds the polarity bit in bit 6. Address 3 holds the flags at the same bit positions as the enables. Unused bits read 0.
- R11: Suppose a synchronous pin change is stable before a rising clock edge. The resulting flag, and an enabled request, appear after the third rising edge and not after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 2 | Register address |
| bus_we | input | 1 | Register write strobe |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data, combinational on bus_addr |
| gie | input | 1 | Global interrupt enable |
| ack | input | 1 | Interrupt acknowledge strobe |
| ack_id | input | 2 | Channel being acknowledged |
| pin_s0 | input | 1 | Synchronous interrupt pin, channel 0 |
| pin_s1 | input | 1 | Synchronous interrupt pin, channel 1 |
| pin_a | input | 1 | Asynchronous edge pin, channel 2 |
| irq_req | output | 3 | Request per channel, bit n = channel n |

## Verification
The bench counts clock edges after each pin change and samples exactly after the third one. This catches a missing or an extra synchroniser stage. It times an acknowledge to land in the same cycle as a fresh edge. A design that let the clear win would then lose that interrupt. The bench runs each sense code in both edge directions and drives level mode low and then high. A design that latched the low level would leave a stale request or a flag behind. On channel 2 it flips the polarity while the pin sits on the triggering side, and checks both that the flag is set and that the masked sequence raises no request. A design that did not mask the request on the enable bit would raise a spurious interrupt.

// File: rtl/irq_sense_pkg.sv
`timescale 1ns/1ps
package irq_sense_pkg;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned ADDR_W  = 2;
  localparam int unsigned NUM_CH  = 3;
  localparam int unsigned NUM_SYN = 2;
  localparam int unsigned ASY_CH  = 2;
  localparam int unsigned POL_BIT = 6;

  typedef logic [ADDR_W-1:0] addr_t;
  localparam addr_t A_MODE = 2'd0;
  localparam addr_t A_EN   = 2'd1;
  localparam addr_t A_ACTL = 2'd2;
  localparam addr_t A_FLAG = 2'd3;

  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_ANY  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_e;

  // bit position of a channel in the enable and flag registers
  function automatic int unsigned chan_bit(input int unsigned ch);
    case (ch)
      0:       chan_bit = 6;
      1:       chan_bit = 7;
      default: chan_bit = 5;
    endcase
  endfunction
endpackage

// File: rtl/irq_rst_sync.sv
`timescale 1ns/1ps
module irq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [1:0] st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= 2'b00;
    else        st_q <= {st_q[0], 1'b1};
  end

  assign rst_q_n = st_q[1];
endmodule

// File: rtl/irq_sync.sv
`timescale 1ns/1ps
module irq_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q, chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], d};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/irq_edge_sense.sv
`timescale 1ns/1ps
module irq_edge_sense
  import irq_sense_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   smp,
  input  sense_e mode,
  output logic   set_o,
  output logic   low_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= smp;
  end

  always_comb begin
    case (mode)
      SENSE_ANY:  set_o = smp ^ prev_q;
      SENSE_FALL: set_o = prev_q & ~smp;
      SENSE_RISE: set_o = ~prev_q & smp;
      default:    set_o = 1'b0;
    endcase
  end

  assign low_o = ~smp;
endmodule

// File: rtl/irq_async_edge.sv
`timescale 1ns/1ps
module irq_async_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic pol,
  output logic set_o
);
  logic cap_clk;
  logic tog_q;
  logic tog_s;
  logic prev_q;

  // rising edge of cap_clk is the selected pin edge
  assign cap_clk = pol ? pin : ~pin;

  always_ff @(posedge cap_clk or negedge rst_n) begin
    if (!rst_n) tog_q <= 1'b0;
    else        tog_q <= ~tog_q;
  end

  irq_sync #(.STAGES(STAGES), .RST_VAL(1'b0)) u_tsync (
    .clk(clk), .rst_n(rst_n), .d(tog_q), .q(tog_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= tog_s;
  end

  assign set_o = tog_s ^ prev_q;
endmodule

// File: rtl/ext_irq_sense.sv
`timescale 1ns/1ps
module ext_irq_sense
  import irq_sense_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              gie,
  input  logic              ack,
  input  logic [1:0]        ack_id,
  input  logic              pin_s0,
  input  logic              pin_s1,
  input  logic              pin_a,
  output logic [NUM_CH-1:0] irq_req
);
  localparam int unsigned MODE_W = 2 * NUM_SYN;

  logic              rst_q_n;
  logic [MODE_W-1:0] mode_q, mode_d;
  logic [NUM_CH-1:0] en_q, en_d;
  logic              pol_q, pol_d;
  logic [NUM_CH-1:0] flag_q, flag_d;
  logic [NUM_CH-1:0] set_ev;
  logic [NUM_SYN-1:0] low_lv;
  logic [NUM_SYN-1:0] pin_in;
  logic              wr_mode, wr_en, wr_actl, wr_flag;
  logic              unused_wdata;

  irq_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n));

  assign pin_in = {pin_s1, pin_s0};

  for (genvar c = 0; c < NUM_SYN; c++) begin : g_syn
    logic smp;
    irq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_psync (
      .clk(clk), .rst_n(rst_q_n), .d(pin_in[c]), .q(smp)
    );
    irq_edge_sense u_det (
      .clk(clk), .rst_n(rst_q_n), .smp(smp),
      .mode(sense_e'(mode_q[2*c +: 2])),
      .set_o(set_ev[c]), .low_o(low_lv[c])
    );
  end

  irq_async_edge #(.STAGES(SYNC_STAGES)) u_async (
    .clk(clk), .rst_n(rst_q_n), .pin(pin_a), .pol(pol_q),
    .set_o(set_ev[ASY_CH])
  );

  // write decode
  always_comb begin
    wr_mode = bus_we && (bus_addr == A_MODE);
    wr_en   = bus_we && (bus_addr == A_EN);
    wr_actl = bus_we && (bus_addr == A_ACTL);
    wr_flag = bus_we && (bus_addr == A_FLAG);
  end

  assign unused_wdata = bus_wdata[4];

  // next state
  always_comb begin
    mode_d = wr_mode ? bus_wdata[MODE_W-1:0] : mode_q;
    pol_d  = wr_actl ? bus_wdata[POL_BIT] : pol_q;
    for (int ch = 0; ch < NUM_CH; ch++) begin
      logic clr;
      en_d[ch]   = wr_en ? bus_wdata[chan_bit(ch)] : en_q[ch];
      clr        = (wr_flag && bus_wdata[chan_bit(ch)]) ||
                   (ack && (ack_id == 2'(ch)));
      flag_d[ch] = set_ev[ch] | (flag_q[ch] & ~clr);
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      mode_q <= '0;
      en_q   <= '0;
      pol_q  <= 1'b0;
      flag_q <= '0;
    end else begin
      if (wr_mode) mode_q <= mode_d;
      if (wr_en)   en_q   <= en_d;
      if (wr_actl) pol_q  <= pol_d;
      flag_q <= flag_d;
    end
  end

  // request generation
  always_comb begin
    for (int ch = 0; ch < NUM_SYN; ch++) begin
      logic src;
      src = (sense_e'(mode_q[2*ch +: 2]) == SENSE_LOW) ? low_lv[ch] : flag_q[ch];
      irq_req[ch] = gie & en_q[ch] & src;
    end
    irq_req[ASY_CH] = gie & en_q[ASY_CH] & flag_q[ASY_CH];
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_MODE: bus_rdata[MODE_W-1:0] = mode_q;
      A_EN:   for (int ch = 0; ch < NUM_CH; ch++) bus_rdata[chan_bit(ch)] = en_q[ch];
      A_ACTL: bus_rdata[POL_BIT] = pol_q;
      default: for (int ch = 0; ch < NUM_CH; ch++) bus_rdata[chan_bit(ch)] = flag_q[ch];
    endcase
  end
endmodule

// File: rtl/irq_sense_chk.sv
`timescale 1ns/1ps
module irq_sense_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] bus_addr,
  input logic       bus_we,
  input logic [7:0] bus_wdata,
  input logic       gie,
  input logic       ack,
  input logic [1:0] ack_id,
  input logic [3:0] mode_q,
  input logic [2:0] flag_q,
  input logic [2:0] irq_req
);
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (irq_req == 3'b000));

  p_req_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req != 3'b000) |-> gie);

  p_level_noflag0_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q[0]) |-> ($past(mode_q[1:0]) != 2'b00));

  p_level_noflag1_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q[1]) |-> ($past(mode_q[3:2]) != 2'b00));

  // R6 / R7: a flag only drops after a one-write or an acknowledge
  p_clear_cause0_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q[0]) |-> $past((bus_we && bus_addr == 2'd3 && bus_wdata[6]) ||
                               (ack && ack_id == 2'd0)));

  p_clear_cause2_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q[2]) |-> $past((bus_we && bus_addr == 2'd3 && bus_wdata[5]) ||
                               (ack && ack_id == 2'd2)));
endmodule

bind ext_irq_sense irq_sense_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .gie(gie), .ack(ack), .ack_id(ack_id),
  .mode_q(mode_q), .flag_q(flag_q), .irq_req(irq_req)
);

// File: tb/tb_ext_irq_sense.sv
`timescale 1ns/1ps
module tb_ext_irq_sense;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] bus_addr;
  logic       bus_we;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       gie, ack;
  logic [1:0] ack_id;
  logic       pin_s0, pin_s1, pin_a;
  logic [2:0] irq_req;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  ext_irq_sense dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .gie(gie), .ack(ack),
    .ack_id(ack_id), .pin_s0(pin_s0), .pin_s1(pin_s1), .pin_a(pin_a),
    .irq_req(irq_req)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    for (int a = 0; a < 4; a++) begin
      reg_rd(2'(a), d);
      chk("R1 register", d, 8'h00);
    end
    chk("R1 requests", {5'b0, irq_req}, 8'h00);
  endtask

  task automatic t_regmap;
    logic [7:0] d;
    reg_wr(2'd1, 8'hFF); reg_rd(2'd1, d); chk("R10 enable bits", d, 8'hE0);
    reg_wr(2'd0, 8'hFF); reg_rd(2'd0, d); chk("R10 mode bits", d, 8'h0F);
    reg_wr(2'd1, 8'h00); reg_wr(2'd0, 8'h00);
    reg_wr(2'd2, 8'hFF); reg_rd(2'd2, d); chk("R10 polarity bit", d, 8'h40);
    reg_wr(2'd2, 8'h00);
    wait_cyc(6);
    reg_wr(2'd3, 8'hFF);
    reg_rd(2'd3, d); chk("R10 flags clear", d, 8'h00);
  endtask

  task automatic t_edges;
    logic [7:0] d;
    reg_wr(2'd0, 8'h0E);          // ch0 falling, ch1 rising
    reg_wr(2'd1, 8'h40);
    gie = 1'b1;
    @(negedge clk); pin_s0 = 1'b0;
    repeat (2) @(posedge clk);
    #1 chk("R11 not after 2nd edge", {7'b0, irq_req[0]}, 8'h00);
    @(posedge clk);
    #1 chk("R11 after 3rd edge / R2 falling", {7'b0, irq_req[0]}, 8'h01);
    reg_wr(2'd3, 8'h40);
    @(negedge clk); pin_s0 = 1'b1;
    wait_cyc(5);
    reg_rd(2'd3, d); chk("R2 rise ignored in falling mode", d, 8'h00);
    @(negedge clk); pin_s1 = 1'b0;
    wait_cyc(5);
    reg_rd(2'd3, d); chk("R2 fall ignored in rising mode", d, 8'h00);
    @(negedge clk); pin_s1 = 1'b1;
    wait_cyc(5);
    reg_rd(2'd3, d); chk("R2 rising sets ch1", d, 8'h80);
    reg_wr(2'd3, 8'hE0);
    reg_wr(2'd1, 8'h00);
  endtask

  task automatic t_anychange_w1c;
    logic [7:0] d;
    reg_wr(2'd0, 8'h05);
    @(negedge clk); pin_s0 = 1'b0;
    wait_cyc(5);
    reg_rd(2'd3, d); chk("R3 falling sets", d, 8'h40);
    reg_wr(2'd3, 8'h40);
    @(negedge clk); pin_s0 = 1'b1;
    wait_cyc(5);
    reg_rd(2'd3, d); chk("R3 rising sets", d, 8'h40);
    @(negedge clk); pin_s1 = 1'b0;
    wait_cyc(5);
    reg_rd(2'd3, d); chk("R3 ch1 set too", d, 8'hC0);
    reg_wr(2'd3, 8'h00);
    reg_rd(2'd3, d); chk("R6 write zero keeps", d, 8'hC0);
    reg_wr(2'd3, 8'h40);
    reg_rd(2'd3, d); chk("R6 one clears ch0 only", d, 8'h80);
    reg_wr(2'd3, 8'h80);
    reg_rd(2'd3, d); chk("R6 one clears ch1", d, 8'h00);
    @(negedge clk); pin_s1 = 1'b1;
    wait_cyc(5);
    reg_wr(2'd3, 8'hE0);
  endtask

  task automatic t_level;
    logic [7:0] d;
    reg_wr(2'd0, 8'h00);
    reg_wr(2'd1, 8'h40);
    gie = 1'b1;
    chk("R4 idle high no request", {7'b0, irq_req[0]}, 8'h00);
    @(negedge clk); pin_s0 = 1'b0;
    repeat (3) @(posedge clk);
    #1 chk("R4 low level requests", {7'b0, irq_req[0]}, 8'h01);
    reg_rd(2'd3, d); chk("R4 no flag in level mode", d, 8'h00);
    @(negedge clk); pin_s0 = 1'b1;
    wait_cyc(4);
    chk("R4 request drops", {7'b0, irq_req[0]}, 8'h00);
    reg_rd(2'd3, d); chk("R4 nothing recorded", d, 8'h00);
    reg_wr(2'd1, 8'h00);
  endtask

  task automatic t_gate;
    logic [7:0] d;
    reg_wr(2'd0, 8'h02);
    gie = 1'b1;
    @(negedge clk); pin_s0 = 1'b0;
    wait_cyc(5);
    reg_rd(2'd3, d); chk("R5 flag set while disabled", d, 8'h40);
    chk("R5 no request while disabled", {7'b0, irq_req[0]}, 8'h00);
    reg_wr(2'd1, 8'h40);
    @(negedge clk); gie = 1'b0;
    #1 chk("R5 gie low masks", {7'b0, irq_req[0]}, 8'h00);
    @(negedge clk); gie = 1'b1;
    #1 chk("R5 both set requests", {7'b0, irq_req[0]}, 8'h01);
    reg_wr(2'd1, 8'h00);
    #1 chk("R5 enable low masks", {7'b0, irq_req[0]}, 8'h00);
    reg_wr(2'd3, 8'h40);
    @(negedge clk); pin_s0 = 1'b1;
    wait_cyc(5);
  endtask

  task automatic t_ack;
    reg_wr(2'd0, 8'h01);
    reg_wr(2'd1, 8'h40);
    gie = 1'b1;
    @(negedge clk); pin_s0 = 1'b0;
    wait_cyc(5);
    @(negedge clk); ack = 1'b1; ack_id = 2'd1;
    @(negedge clk); ack = 1'b0;
    #1 chk("R7 ack of other channel keeps", {7'b0, irq_req[0]}, 8'h01);
    @(negedge clk); ack = 1'b1; ack_id = 2'd0;
    @(negedge clk); ack = 1'b0;
    #1 chk("R7 ack clears", {7'b0, irq_req[0]}, 8'h00);
    @(negedge clk); pin_s0 = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk); ack = 1'b1; ack_id = 2'd0;
    @(negedge clk); ack = 1'b0;
    #1 chk("R7 set wins over ack", {7'b0, irq_req[0]}, 8'h01);
    reg_wr(2'd3, 8'h40);
    reg_wr(2'd1, 8'h00);
  endtask

  task automatic t_async;
    logic [7:0] d;
    reg_wr(2'd1, 8'h20);
    gie = 1'b1;
    @(negedge clk); pin_a = 1'b0;
    wait_cyc(6);
    chk("R8 falling with polarity 0", {7'b0, irq_req[2]}, 8'h01);
    reg_wr(2'd3, 8'h20);
    wait_cyc(2);
    chk("R6 async flag cleared", {7'b0, irq_req[2]}, 8'h00);
    @(negedge clk); pin_a = 1'b1;
    wait_cyc(6);
    chk("R8 rising ignored with polarity 0", {7'b0, irq_req[2]}, 8'h00);
    reg_wr(2'd2, 8'h40);
    wait_cyc(6);
    chk("R9 polarity change raises flag", {7'b0, irq_req[2]}, 8'h01);
    reg_wr(2'd3, 8'h20);
    @(negedge clk); pin_a = 1'b0;
    wait_cyc(6);
    chk("R8 falling ignored with polarity 1", {7'b0, irq_req[2]}, 8'h00);
    @(negedge clk); pin_a = 1'b1;
    wait_cyc(6);
    chk("R8 rising with polarity 1", {7'b0, irq_req[2]}, 8'h01);
    reg_wr(2'd3, 8'h20);
    @(negedge clk); pin_a = 1'b0;
    wait_cyc(6);
    reg_wr(2'd1, 8'h00);
    reg_wr(2'd2, 8'h00);
    wait_cyc(6);
    chk("R9 masked during change", {7'b0, irq_req[2]}, 8'h00);
    reg_rd(2'd3, d); chk("R9 change sets flag", d, 8'h20);
    reg_wr(2'd3, 8'h20);
    reg_wr(2'd1, 8'h20);
    wait_cyc(6);
    chk("R9 no spurious request", {7'b0, irq_req[2]}, 8'h00);
    reg_rd(2'd3, d); chk("R9 flag stays clear", d, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0;
    gie = 1'b0; ack = 1'b0; ack_id = '0;
    pin_s0 = 1'b1; pin_s1 = 1'b1; pin_a = 1'b1;
    wait_cyc(4);
    rst_n = 1'b1;
    wait_cyc(4);
    t_reset();
    t_regmap();
    t_edges();
    t_anychange_w1c();
    t_level();
    t_gate();
    t_ack();
    t_async();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule